// File: doc/BRIEF.md
# Hashed Page Table Walker with Non-Recursive Walker Fault

This block handles one translation miss at a time. From the missing virtual address and the region register chosen by the address's top bits, it forms the address of an entry in a hashed page table. It translates that address through the data TLB lookup port. On a hit it reads the 8-byte entry from memory and passes it unchanged to the TLB insert port, because an entry is already in insert format.

When the walker's own lookup of the table address misses, the block does not start a second walk. It ends the walk and raises a walker-translation fault on a vector that depends on whether the original miss came from a data or an instruction access. In the same cycle it loads three capture registers: the table address that missed, the original faulting address, and translation info (key and page size) taken from the region register that the table address selects. When the walker is disabled, a miss raises the ordinary TLB-miss fault straight away.

Every data interface is valid/ready. A source holds valid and the payload steady until it sees ready at a clock edge. The walker holds `lk_valid`/`lk_va`, `mem_req_valid`/`mem_addr` and `ins_valid`/`ins_*` until the matching ready. Memory responses have no back-pressure: the walker always accepts `mem_rsp_valid` while it waits for data.

Top module: `hpt_walker`

## Requirements
- R1: `miss_ready` is high only when the walker is idle. A miss is taken on `miss_valid && miss_ready`, and `busy` stays high from the cycle after acceptance until the walk has finished.
- R2: The table address is `tbl_base + (((va[60:0] >> ps) & (2^IDX_W - 1)) << 3)`. Here `ps` is the page size from the region register whose index is `va[63:61]`, and IDX_W defaults to 16.
- R3: The table address appears on the lookup port two cycles after acceptance, for data and instruction misses alike. `lk_valid` and `lk_va` stay steady until `lk_ready`.
- R4: On a lookup hit the walker issues a memory read at `lk_pa` and holds it until `mem_req_ready`. It then offers the returned 64-bit data unchanged on `ins_data`, with `ins_va` equal to the original address and `ins_itlb` equal to the origin (1 for instruction).
- R5: On a lookup miss the walker makes no memory read. In the next cycle it pulses `flt_valid` for exactly one cycle with `flt_vec` = 2'b10 for a data miss or 2'b11 for an instruction miss, then returns to idle.
- R6: During the walker fault pulse, `cap_hash` equals the table address whose lookup missed.
- R7: During the walker fault pulse, `cap_fa` equals the original faulting address.
- R8: During the walker fault pulse, `cap_key` and `cap_ps` equal the region ID and page size of the region register indexed by bits 63:61 of the table address, which may differ from the faulting address's region.
- R9: With `walk_en` low, an accepted miss makes no lookup. It pulses `flt_valid` the cycle after acceptance with `flt_vec` = 2'b00 (data) or 2'b01 (instruction), and the capture registers keep their values.
- R10: The capture registers change only on a walker fault. A successful walk leaves them unchanged.
- R11: A region register write (`rr_we`, index `rr_idx`) takes effect from the next cycle. All region registers and capture registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| walk_en | input | 1 | Enables table walks |
| tbl_base | input | 64 | Hashed table base virtual address |
| rr_we | input | 1 | Region register write strobe |
| rr_idx | input | 3 | Region register index |
| rr_rid | input | 24 | Region ID to write |
| rr_ps | input | 6 | Preferred page size (log2) to write |
| miss_valid | input | 1 | Miss request valid |
| miss_ready | output | 1 | Walker can take a miss |
| miss_va | input | 64 | Missing virtual address |
| miss_instr | input | 1 | Miss came from instruction fetch |
| busy | output | 1 | Walk in progress |
| lk_valid | output | 1 | Data TLB lookup request |
| lk_ready | input | 1 | Lookup result present |
| lk_va | output | 64 | Table address to translate |
| lk_hit | input | 1 | Lookup hit |
| lk_pa | input | 64 | Translated table address |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_addr | output | 64 | Read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Table entry |
| ins_valid | output | 1 | TLB insert request |
| ins_ready | input | 1 | Insert accepted |
| ins_va | output | 64 | Address being mapped |
| ins_data | output | 64 | Entry to insert |
| ins_itlb | output | 1 | Insert targets the instruction TLB |
| flt_valid | output | 1 | Fault pulse |
| flt_vec | output | 2 | Fault vector: bit1 walker class, bit0 instruction origin |
| cap_hash | output | 64 | Captured table address |
| cap_fa | output | 64 | Captured faulting address |
| cap_key | output | 24 | Captured region ID |
| cap_ps | output | 6 | Captured page size |

## Verification
The bench puts the table in a different region from the faulting address, so translation info taken from the wrong region register shows up as a wrong `cap_key`/`cap_ps`. It runs walker faults of both origins, and a design that kept walking or fetched after a miss would show a memory request or a missing or wrong vector. It holds back ready on the lookup, memory and insert ports to catch payloads that change or are dropped under back-pressure. Disabled walks and successful walks both check that the capture registers do not move, which catches a capture enable tied to every fault or to every walk.

// File: rtl/hpw_pkg.sv
package hpw_pkg;
  localparam int unsigned VA_W_D    = 64;
  localparam int unsigned RGN_W_D   = 3;
  localparam int unsigned RID_W_D   = 24;
  localparam int unsigned PS_W_D    = 6;
  localparam int unsigned IDX_W_D   = 16;
  localparam int unsigned ENTRY_W_D = 64;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HASH, ST_LOOKUP, ST_FETCH, ST_INSERT, ST_FAULT
  } wlk_state_t;

  // fault vector: bit1 = walker class, bit0 = instruction origin
  localparam logic [1:0] VEC_DMISS = 2'b00;
  localparam logic [1:0] VEC_IMISS = 2'b01;
  localparam logic [1:0] VEC_WDATA = 2'b10;
  localparam logic [1:0] VEC_WINST = 2'b11;
endpackage

// File: rtl/hpw_rr_file.sv
module hpw_rr_file #(
  parameter int unsigned RGN_W = 3,
  parameter int unsigned RID_W = 24,
  parameter int unsigned PS_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [RGN_W-1:0] widx,
  input  logic [RID_W-1:0] wrid,
  input  logic [PS_W-1:0]  wps,
  input  logic [RGN_W-1:0] a_idx,
  output logic [PS_W-1:0]  a_ps,
  input  logic [RGN_W-1:0] b_idx,
  output logic [RID_W-1:0] b_rid,
  output logic [PS_W-1:0]  b_ps
);
  localparam int unsigned NRGN = 1 << RGN_W;

  logic [RID_W-1:0] rid_q [NRGN];
  logic [PS_W-1:0]  ps_q  [NRGN];

  for (genvar i = 0; i < NRGN; i++) begin : g_rr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rid_q[i] <= '0;
        ps_q[i]  <= '0;
      end else if (we && widx == RGN_W'(i)) begin
        rid_q[i] <= wrid;
        ps_q[i]  <= wps;
      end
    end
  end

  assign a_ps  = ps_q[a_idx];
  assign b_rid = rid_q[b_idx];
  assign b_ps  = ps_q[b_idx];
endmodule

// File: rtl/hpw_hash.sv
module hpw_hash #(
  parameter int unsigned VA_W  = 64,
  parameter int unsigned RGN_W = 3,
  parameter int unsigned PS_W  = 6,
  parameter int unsigned IDX_W = 16
) (
  input  logic [VA_W-RGN_W-1:0] va_off,
  input  logic [PS_W-1:0]       ps,
  input  logic [VA_W-1:0]       base,
  output logic [VA_W-1:0]       hash
);
  localparam logic [VA_W-1:0] IDX_MASK = (VA_W'(1) << IDX_W) - VA_W'(1);

  logic [VA_W-1:0] vpn;
  logic [VA_W-1:0] off;

  always_comb begin
    vpn  = {{RGN_W{1'b0}}, va_off} >> ps;
    off  = (vpn & IDX_MASK) << 3;
    hash = base + off;
  end
endmodule

// File: rtl/hpw_capture.sv
module hpw_capture #(
  parameter int unsigned VA_W  = 64,
  parameter int unsigned RID_W = 24,
  parameter int unsigned PS_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [VA_W-1:0]  hash_in,
  input  logic [VA_W-1:0]  fa_in,
  input  logic [RID_W-1:0] key_in,
  input  logic [PS_W-1:0]  ps_in,
  output logic [VA_W-1:0]  hash_q,
  output logic [VA_W-1:0]  fa_q,
  output logic [RID_W-1:0] key_q,
  output logic [PS_W-1:0]  ps_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hash_q <= '0;
      fa_q   <= '0;
      key_q  <= '0;
      ps_q   <= '0;
    end else if (load) begin
      hash_q <= hash_in;
      fa_q   <= fa_in;
      key_q  <= key_in;
      ps_q   <= ps_in;
    end
  end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpw_pkg::*;
#(
  parameter int unsigned VA_W    = VA_W_D,
  parameter int unsigned RGN_W   = RGN_W_D,
  parameter int unsigned RID_W   = RID_W_D,
  parameter int unsigned PS_W    = PS_W_D,
  parameter int unsigned IDX_W   = IDX_W_D,
  parameter int unsigned ENTRY_W = ENTRY_W_D
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               walk_en,
  input  logic [VA_W-1:0]    tbl_base,
  input  logic               rr_we,
  input  logic [RGN_W-1:0]   rr_idx,
  input  logic [RID_W-1:0]   rr_rid,
  input  logic [PS_W-1:0]    rr_ps,
  input  logic               miss_valid,
  output logic               miss_ready,
  input  logic [VA_W-1:0]    miss_va,
  input  logic               miss_instr,
  output logic               busy,
  output logic               lk_valid,
  input  logic               lk_ready,
  output logic [VA_W-1:0]    lk_va,
  input  logic               lk_hit,
  input  logic [VA_W-1:0]    lk_pa,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [VA_W-1:0]    mem_addr,
  input  logic               mem_rsp_valid,
  input  logic [ENTRY_W-1:0] mem_rsp_data,
  output logic               ins_valid,
  input  logic               ins_ready,
  output logic [VA_W-1:0]    ins_va,
  output logic [ENTRY_W-1:0] ins_data,
  output logic               ins_itlb,
  output logic               flt_valid,
  output logic [1:0]         flt_vec,
  output logic [VA_W-1:0]    cap_hash,
  output logic [VA_W-1:0]    cap_fa,
  output logic [RID_W-1:0]   cap_key,
  output logic [PS_W-1:0]    cap_ps
);
  localparam int unsigned OFF_W = VA_W - RGN_W;

  wlk_state_t         state_q;
  logic [VA_W-1:0]    va_q;
  logic               instr_q;
  logic               wclass_q;
  logic [VA_W-1:0]    hash_q;
  logic [VA_W-1:0]    pa_q;
  logic [ENTRY_W-1:0] data_q;
  logic               sent_q;

  logic [PS_W-1:0]    va_ps;
  logic [RID_W-1:0]   tbl_rid;
  logic [PS_W-1:0]    tbl_ps;
  logic [VA_W-1:0]    hash_c;
  logic               cap_load;

  hpw_rr_file #(.RGN_W(RGN_W), .RID_W(RID_W), .PS_W(PS_W)) u_rr (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rr_we),
    .widx  (rr_idx),
    .wrid  (rr_rid),
    .wps   (rr_ps),
    .a_idx (va_q[VA_W-1 -: RGN_W]),
    .a_ps  (va_ps),
    .b_idx (hash_q[VA_W-1 -: RGN_W]),
    .b_rid (tbl_rid),
    .b_ps  (tbl_ps)
  );

  hpw_hash #(.VA_W(VA_W), .RGN_W(RGN_W), .PS_W(PS_W), .IDX_W(IDX_W)) u_hash (
    .va_off (va_q[OFF_W-1:0]),
    .ps     (va_ps),
    .base   (tbl_base),
    .hash   (hash_c)
  );

  assign cap_load = (state_q == ST_LOOKUP) && lk_ready && !lk_hit;

  hpw_capture #(.VA_W(VA_W), .RID_W(RID_W), .PS_W(PS_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cap_load),
    .hash_in (hash_q),
    .fa_in   (va_q),
    .key_in  (tbl_rid),
    .ps_in   (tbl_ps),
    .hash_q  (cap_hash),
    .fa_q    (cap_fa),
    .key_q   (cap_key),
    .ps_q    (cap_ps)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      va_q     <= '0;
      instr_q  <= 1'b0;
      wclass_q <= 1'b0;
      hash_q   <= '0;
      pa_q     <= '0;
      data_q   <= '0;
      sent_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (miss_valid) begin
          va_q     <= miss_va;
          instr_q  <= miss_instr;
          wclass_q <= walk_en;
          state_q  <= walk_en ? ST_HASH : ST_FAULT;
        end
        ST_HASH: begin
          hash_q  <= hash_c;
          state_q <= ST_LOOKUP;
        end
        ST_LOOKUP: if (lk_ready) begin
          pa_q    <= lk_pa;
          state_q <= lk_hit ? ST_FETCH : ST_FAULT;
        end
        ST_FETCH: begin
          if (!sent_q) begin
            if (mem_req_ready) sent_q <= 1'b1;
          end else if (mem_rsp_valid) begin
            data_q  <= mem_rsp_data;
            sent_q  <= 1'b0;
            state_q <= ST_INSERT;
          end
        end
        ST_INSERT: if (ins_ready) state_q <= ST_IDLE;
        ST_FAULT:  state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign miss_ready    = (state_q == ST_IDLE);
  assign busy          = (state_q != ST_IDLE);
  assign lk_valid      = (state_q == ST_LOOKUP);
  assign lk_va         = hash_q;
  assign mem_req_valid = (state_q == ST_FETCH) && !sent_q;
  assign mem_addr      = pa_q;
  assign ins_valid     = (state_q == ST_INSERT);
  assign ins_va        = va_q;
  assign ins_data      = data_q;
  assign ins_itlb      = instr_q;
  assign flt_valid     = (state_q == ST_FAULT);
  assign flt_vec       = {wclass_q, instr_q};

  // R5: the fault indication lasts a single cycle
  a_r5_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> !flt_valid);

  // R5: a lookup miss ends the walk in a walker fault, never a second walk
  a_r5_no_recursion: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready && !lk_hit |=> flt_valid && flt_vec[1] && !lk_valid && !mem_req_valid);

  // R3: lookup request held steady under back-pressure
  a_r3_lk_hold: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && !lk_ready |=> lk_valid && $stable(lk_va));

  // R4: memory request and insert payload held steady under back-pressure
  a_r4_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr));
  a_r4_ins_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && !ins_ready |=> ins_valid && $stable(ins_data) && $stable(ins_va));

  // R10: captured faulting address moves only with a walker fault
  a_r10_cap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_fa) |-> flt_valid && flt_vec[1]);

  // R1: no new miss is accepted while a walk is running
  a_r1_single: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !miss_ready);
endmodule

// File: tb/sim_hpt_walker.sv
module sim_hpt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        walk_en = 1'b1;
  logic [63:0] tbl_base = 64'hA000_0000_0010_0000;
  logic        rr_we = 1'b0;
  logic [2:0]  rr_idx = '0;
  logic [23:0] rr_rid = '0;
  logic [5:0]  rr_ps = '0;
  logic        miss_valid = 1'b0;
  logic        miss_ready;
  logic [63:0] miss_va = '0;
  logic        miss_instr = 1'b0;
  logic        busy;
  logic        lk_valid;
  logic        lk_ready = 1'b0;
  logic [63:0] lk_va;
  logic        lk_hit = 1'b0;
  logic [63:0] lk_pa = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        ins_valid;
  logic        ins_ready = 1'b0;
  logic [63:0] ins_va;
  logic [63:0] ins_data;
  logic        ins_itlb;
  logic        flt_valid;
  logic [1:0]  flt_vec;
  logic [63:0] cap_hash;
  logic [63:0] cap_fa;
  logic [23:0] cap_key;
  logic [5:0]  cap_ps;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [23:0] m_rid [8];
  logic [5:0]  m_ps  [8];

  always #5 clk = ~clk;

  hpt_walker u0 (
    .clk(clk), .rst_n(rst_n), .walk_en(walk_en), .tbl_base(tbl_base),
    .rr_we(rr_we), .rr_idx(rr_idx), .rr_rid(rr_rid), .rr_ps(rr_ps),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_va(miss_va),
    .miss_instr(miss_instr), .busy(busy),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_va(lk_va), .lk_hit(lk_hit), .lk_pa(lk_pa),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_va(ins_va), .ins_data(ins_data),
    .ins_itlb(ins_itlb), .flt_valid(flt_valid), .flt_vec(flt_vec),
    .cap_hash(cap_hash), .cap_fa(cap_fa), .cap_key(cap_key), .cap_ps(cap_ps)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_hash(input logic [63:0] va);
    logic [63:0] vpn;
    vpn = {3'b000, va[60:0]} >> m_ps[va[63:61]];
    return tbl_base + ({48'h0, vpn[15:0]} << 3);
  endfunction

  task automatic wr_rr(input int idx, input logic [23:0] rid, input logic [5:0] ps);
    @(negedge clk);
    rr_we = 1'b1; rr_idx = 3'(idx); rr_rid = rid; rr_ps = ps;
    @(negedge clk);
    rr_we = 1'b0;
    m_rid[idx] = rid; m_ps[idx] = ps;
  endtask

  task automatic send_miss(input logic [63:0] va, input logic instr);
    @(negedge clk);
    chk("R1 ready when idle", 64'(miss_ready), 64'd1);
    miss_valid = 1'b1; miss_va = va; miss_instr = instr;
    @(negedge clk);
    miss_valid = 1'b0;
    chk("R1 busy after accept", 64'(busy), 64'd1);
    chk("R1 not ready while busy", 64'(miss_ready), 64'd0);
  endtask

  // full walk; hit selects insert path or walker fault
  task automatic walk(input logic [63:0] va, input logic instr, input logic hit,
                      input logic [63:0] pa, input logic [63:0] ent, input int dly);
    logic [63:0] h;
    logic [63:0] c_hash, c_fa;
    logic [23:0] c_key;
    logic [5:0]  c_ps;
    h = exp_hash(va);
    c_hash = cap_hash; c_fa = cap_fa; c_key = cap_key; c_ps = cap_ps;
    send_miss(va, instr);
    chk("R3 no lookup yet", 64'(lk_valid), 64'd0);
    @(negedge clk);
    chk("R3 lookup two cycles after accept", 64'(lk_valid), 64'd1);
    chk("R2 table address", lk_va, h);
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      chk("R3 lookup held", 64'(lk_valid), 64'd1);
      chk("R3 lookup address held", lk_va, h);
    end
    lk_ready = 1'b1; lk_hit = hit; lk_pa = pa;
    @(negedge clk);
    lk_ready = 1'b0; lk_hit = 1'b0;
    if (hit) begin
      chk("R4 memory read issued", 64'(mem_req_valid), 64'd1);
      chk("R4 memory address", mem_addr, pa);
      for (int i = 0; i < dly; i++) begin
        @(negedge clk);
        chk("R4 memory request held", 64'(mem_req_valid), 64'd1);
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      chk("R4 single memory request", 64'(mem_req_valid), 64'd0);
      @(negedge clk);
      mem_rsp_valid = 1'b1; mem_rsp_data = ent;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      chk("R4 insert valid", 64'(ins_valid), 64'd1);
      chk("R4 insert data unchanged", ins_data, ent);
      chk("R4 insert address", ins_va, va);
      chk("R4 insert target by origin", 64'(ins_itlb), 64'(instr));
      for (int i = 0; i < dly; i++) @(negedge clk);
      chk("R4 insert held", ins_data, ent);
      ins_ready = 1'b1;
      @(negedge clk);
      ins_ready = 1'b0;
      chk("R1 idle after insert", 64'(busy), 64'd0);
      chk("R10 captures kept (hash)", cap_hash, c_hash);
      chk("R10 captures kept (fa)", cap_fa, c_fa);
      chk("R10 captures kept (key)", 64'(cap_key), 64'(c_key));
      chk("R10 captures kept (ps)", 64'(cap_ps), 64'(c_ps));
    end else begin
      chk("R5 fault pulse", 64'(flt_valid), 64'd1);
      chk("R5 walker vector", 64'(flt_vec), 64'({1'b1, instr}));
      chk("R5 no memory read", 64'(mem_req_valid), 64'd0);
      chk("R6 captured table address", cap_hash, h);
      chk("R7 captured faulting address", cap_fa, va);
      chk("R8 captured key from table region", 64'(cap_key), 64'(m_rid[h[63:61]]));
      chk("R8 captured page size from table region", 64'(cap_ps), 64'(m_ps[h[63:61]]));
      @(negedge clk);
      chk("R5 pulse ends", 64'(flt_valid), 64'd0);
      chk("R5 back to idle", 64'(busy), 64'd0);
    end
  endtask

  task automatic t_reset();
    chk("R11 idle after reset", 64'(busy), 64'd0);
    chk("R11 ready after reset", 64'(miss_ready), 64'd1);
    chk("R11 no fault after reset", 64'(flt_valid), 64'd0);
    chk("R11 capture reset", cap_hash | cap_fa, 64'd0);
    chk("R11 capture info reset", 64'({cap_key, cap_ps}), 64'd0);
  endtask

  task automatic t_disabled(input logic instr);
    logic [63:0] c_hash, c_fa;
    c_hash = cap_hash; c_fa = cap_fa;
    walk_en = 1'b0;
    send_miss(64'h4000_0000_0000_9000, instr);
    chk("R9 ordinary fault pulse", 64'(flt_valid), 64'd1);
    chk("R9 ordinary vector", 64'(flt_vec), 64'({1'b0, instr}));
    chk("R9 no lookup", 64'(lk_valid), 64'd0);
    chk("R9 captures unchanged (hash)", cap_hash, c_hash);
    chk("R9 captures unchanged (fa)", cap_fa, c_fa);
    @(negedge clk);
    chk("R9 back to idle", 64'(busy), 64'd0);
    walk_en = 1'b1;
  endtask

  task automatic t_rr_update();
    logic [63:0] va;
    va = 64'h4000_0000_1234_5000;
    wr_rr(5, 24'h0C0FFE, 6'd16);
    walk(va, 1'b0, 1'b0, 64'h0, 64'h0, 0);
    chk("R11 new region value captured", 64'(cap_key), 64'h0C0FFE);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin m_rid[i] = '0; m_ps[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    wr_rr(2, 24'h00A002, 6'd12);
    wr_rr(5, 24'h05A5A5, 6'd14);
    wr_rr(3, 24'h0B0B03, 6'd20);
    walk(64'h4000_0000_1234_5000, 1'b0, 1'b1, 64'h0000_0000_8000_1238, 64'h1111_2222_3333_4444, 0);
    walk(64'h6000_00AB_CDEF_0000, 1'b1, 1'b1, 64'h0000_0000_9000_0040, 64'hDEAD_BEEF_0BAD_F00D, 3);
    walk(64'h4000_0000_1234_5000, 1'b0, 1'b0, 64'h0, 64'h0, 2);
    walk(64'h6000_00AB_CDEF_0000, 1'b1, 1'b0, 64'h0, 64'h0, 0);
    t_disabled(1'b0);
    t_disabled(1'b1);
    walk(64'h4000_0000_0777_1000, 1'b1, 1'b1, 64'h0000_0000_A000_0008, 64'h0123_4567_89AB_CDEF, 1);
    t_rr_update();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule